// File: doc/BRIEF.md
# Fly-by DMA transfer controller

This block sequences direct transfers from a source device into a destination memory over a shared data bus. The data itself never passes through the controller. Each transfer takes four clock slots, counted by a two-bit phase counter. Decoding that counter gives an active-low read strobe for the source and an active-low write strobe for the destination. The write pulse sits inside the read window, so the memory captures the word while the source is still driving the bus. With a 4 MHz clock this gives one million transfers per second when no wait is inserted.

Two loadable counters supply the addresses, one for the source port and one for the destination. Both advance together when the phase counter wraps. Software loads a port pointer, a destination start and a destination stop through a small write port, then writes a go bit. Sequencing ends when the destination address reaches the stop value, and a sticky done flag is set. A wait input can hold the sequence, but only at the boundary between transfers. An abort bit ends a running sequence at once.

Top module: `flyby_dma`

## Requirements
- R1: A synchronous reset clears busy, done, both address counters, and all three programmable values to 0, and drives rd_n and wr_n high.
- R2: A transfer occupies four cycles, with phases 0, 1, 2 and 3 in that order. rd_n is low in phases 1 and 2. wr_n is low in phase 2 only. N transfers without wait give 2N cycles of rd_n low and N cycles of wr_n low.
- R3: While busy is low, rd_n and wr_n stay high.
- R4: A write with wr_sel = 3 and wr_data bit 0 set, made while idle, starts a sequence. On the next cycle busy is high, src_addr equals the port pointer (wr_sel = 0, low PW bits), dst_addr equals the start value (wr_sel = 1), and done is clear.
- R5: Each completed transfer adds one to src_addr and to dst_addr, both modulo their widths. The addresses do not change within a transfer.
- R6: When dst_addr after an increment equals the stop value (wr_sel = 2), busy falls and done rises in that same cycle. A run of N = stop - start transfers with no wait keeps busy high for exactly 4N cycles.
- R7: A go issued while start equals stop makes no transfer: on the next cycle busy is low, done is high, and the strobes stay high.
- R8: wait_i is honoured only in phase 0 of a busy sequence. While it is high there, the phase holds and both strobes stay high. In phases 1 to 3 it has no effect.
- R9: While busy, writes to wr_sel 0, 1 and 2 are ignored, and so is the go bit.
- R10: A write with wr_sel = 3 and wr_data bit 1 set, made while busy, aborts the sequence. On the next cycle busy and done are low, the strobes are high, and the addresses keep the values of the interrupted transfer. Abort takes priority over a completion in the same cycle.
- R11: done stays set until reset or the next go.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 pointer, 1 start, 2 stop, 3 control |
| wr_data | input | AW | Write data; control bit 0 = go, bit 1 = abort |
| wait_i | input | 1 | Stall request, sampled at the transfer boundary |
| rd_n | output | 1 | Active-low source read strobe |
| wr_n | output | 1 | Active-low destination write strobe |
| src_addr | output | PW | Source port address |
| dst_addr | output | AW | Destination memory address |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sticky end-of-block flag |

## Verification
An abort write and the completion of the final transfer can land on the same clock edge. Both try to end the sequence, but only completion sets done and advances the addresses. The bench runs a one-transfer block, waits until phase 3, and issues the abort on that exact cycle. It then expects busy low, done low, and dst_addr still at the start value. Random runs also place wait pulses and ignored busy-time writes on the boundary cycle where a transfer finishes, and compare every cycle against a bench model.

// File: rtl/flyby_pkg.sv
package flyby_pkg;
  typedef enum logic [1:0] {
    SEL_PTR   = 2'd0,
    SEL_START = 2'd1,
    SEL_STOP  = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  localparam int CTRL_GO    = 0;
  localparam int CTRL_ABORT = 1;
  localparam int PHW        = 2;
  localparam logic [PHW-1:0] PH_IDLE  = 2'd0;
  localparam logic [PHW-1:0] PH_RD    = 2'd1;
  localparam logic [PHW-1:0] PH_WR    = 2'd2;
  localparam logic [PHW-1:0] PH_LAST  = 2'd3;
endpackage

// File: rtl/flyby_regs.sv
module flyby_regs
  import flyby_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  output logic [PW-1:0] ptr_q,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] stop_q,
  output logic          go,
  output logic          abort
);
  logic ctrl_hit;
  logic cfg_ok;

  assign ctrl_hit = wr_en && (wr_sel == SEL_CTRL);
  assign cfg_ok   = wr_en && !busy;
  assign go       = ctrl_hit && wr_data[CTRL_GO] && !busy;
  assign abort    = ctrl_hit && wr_data[CTRL_ABORT] && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      start_q <= '0;
      stop_q  <= '0;
    end else if (cfg_ok) begin
      case (wr_sel)
        SEL_PTR:   ptr_q   <= wr_data[PW-1:0];
        SEL_START: start_q <= wr_data;
        SEL_STOP:  stop_q  <= wr_data;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/flyby_phase.sv
module flyby_phase
  import flyby_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           run,
  input  logic           wait_i,
  output logic [PHW-1:0] phase,
  output logic           carry,
  output logic           rd_n,
  output logic           wr_n
);
  logic stall;

  // Wait only counts at the boundary slot; mid-transfer it is not looked at.
  assign stall = (phase == PH_IDLE) && wait_i;
  assign carry = run && (phase == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)
      phase <= PH_IDLE;
    else if (run && !stall)
      phase <= phase + 1'b1;
  end

  // The write pulse sits strictly inside the read window.
  assign rd_n = !(run && ((phase == PH_RD) || (phase == PH_WR)));
  assign wr_n = !(run && (phase == PH_WR));
endmodule

// File: rtl/flyby_addr_cnt.sv
module flyby_addr_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= ld_val;
    else if (inc)
      q <= q + 1'b1;
  end
endmodule

// File: rtl/flyby_dma.sv
module flyby_dma
  import flyby_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          wait_i,
  output logic          rd_n,
  output logic          wr_n,
  output logic [PW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          busy,
  output logic          done
);
  logic [PW-1:0]  ptr_q;
  logic [AW-1:0]  start_q;
  logic [AW-1:0]  stop_q;
  logic           go_w;
  logic           ab_w;
  logic           carry_w;
  logic [PHW-1:0] phase_w;
  logic           step_w;
  logic           finish_w;
  logic           empty_w;
  logic [AW-1:0]  dst_next;
  logic           busy_q;
  logic           done_q;

  flyby_regs #(.AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy_q), .ptr_q(ptr_q), .start_q(start_q), .stop_q(stop_q),
    .go(go_w), .abort(ab_w)
  );

  flyby_phase u_phase (
    .clk(clk), .rst(rst), .clr(go_w | ab_w), .run(busy_q), .wait_i(wait_i),
    .phase(phase_w), .carry(carry_w), .rd_n(rd_n), .wr_n(wr_n)
  );

  // Abort freezes the addresses of the interrupted transfer.
  assign step_w   = carry_w && !ab_w;
  assign dst_next = dst_addr + 1'b1;
  assign finish_w = step_w && (dst_next == stop_q);
  assign empty_w  = (start_q == stop_q);

  flyby_addr_cnt #(.W(PW)) u_src (
    .clk(clk), .rst(rst), .load(go_w), .ld_val(ptr_q), .inc(step_w), .q(src_addr)
  );

  flyby_addr_cnt #(.W(AW)) u_dst (
    .clk(clk), .rst(rst), .load(go_w), .ld_val(start_q), .inc(step_w), .q(dst_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (go_w) begin
      busy_q <= !empty_w;
      done_q <= empty_w;
    end else if (ab_w) begin
      busy_q <= 1'b0;
    end else if (finish_w) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wait_i,
  input logic          rd_n,
  input logic          wr_n,
  input logic [AW-1:0] dst_addr,
  input logic          busy,
  input logic          done,
  input logic [1:0]    phase,
  input logic          go,
  input logic          ab
);
  // R2: write pulse only while the read strobe is active
  a_r2_write_inside_read: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !rd_n);

  // R3: idle keeps both strobes high
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (rd_n && wr_n));

  // R4: a go always leaves the block running or finished
  a_r4_go_starts: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy || done));

  // R5: the destination moves by one step while running
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$stable(dst_addr)) |-> (dst_addr == AW'($past(dst_addr) + 1'b1)));

  // R8: wait at the boundary holds the phase
  a_r8_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && (phase == 2'd0) && wait_i) |=> (phase == 2'd0));

  // R10: abort returns to idle without done
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
    ab |=> (!busy && !done && rd_n && wr_n));

  // R11: done holds until the next go
  a_r11_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !go) |=> done);

  // R6: running and finished are exclusive
  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

bind flyby_dma flyby_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wait_i(wait_i), .rd_n(rd_n), .wr_n(wr_n),
  .dst_addr(dst_addr), .busy(busy), .done(done), .phase(phase_w),
  .go(go_w), .ab(ab_w)
);

// File: tb/sim_flyby_dma.sv
module sim_flyby_dma;
  localparam int AW = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic          wait_i = 1'b0;
  logic          rd_n, wr_n, busy, done;
  logic [PW-1:0] src_addr;
  logic [AW-1:0] dst_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  string tag = "R1";

  flyby_dma #(.AW(AW), .PW(PW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wait_i(wait_i), .rd_n(rd_n), .wr_n(wr_n), .src_addr(src_addr),
    .dst_addr(dst_addr), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  // Bench model, built from the requirements
  logic          m_busy, m_done;
  logic [1:0]    m_phase;
  logic [PW-1:0] m_src, m_ptr;
  logic [AW-1:0] m_dst, m_start, m_stop;
  bit            m_go, m_ab, m_idle;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_phase = 0; m_src = '0; m_dst = '0;
      m_ptr = '0; m_start = '0; m_stop = '0;
    end else begin
      m_idle = !m_busy;
      m_go = wr_en && wr_sel == 2'd3 && wr_data[0] && m_idle;
      m_ab = wr_en && wr_sel == 2'd3 && wr_data[1] && !m_idle;
      if (m_go) begin
        m_src = m_ptr; m_dst = m_start; m_phase = 0;
        m_busy = (m_start != m_stop); m_done = (m_start == m_stop);
      end else if (m_ab) begin
        m_busy = 0; m_phase = 0;
      end else if (m_busy && !(m_phase == 2'd0 && wait_i)) begin
        if (m_phase == 2'd3) begin
          m_phase = 0; m_src = m_src + 1'b1; m_dst = m_dst + 1'b1;
          if (m_dst == m_stop) begin m_busy = 0; m_done = 1; end
        end else m_phase = m_phase + 1'b1;
      end
      if (wr_en && m_idle) begin
        if (wr_sel == 2'd0) m_ptr = wr_data[PW-1:0];
        if (wr_sel == 2'd1) m_start = wr_data;
        if (wr_sel == 2'd2) m_stop = wr_data;
      end
    end
  end

  function automatic logic exp_rd(logic b, logic [1:0] ph);
    return !(b && (ph == 2'd1 || ph == 2'd2));
  endfunction

  function automatic logic exp_wr(logic b, logic [1:0] ph);
    return !(b && ph == 2'd2);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    n_chk++;
    if (busy !== m_busy || done !== m_done || rd_n !== exp_rd(m_busy, m_phase) ||
        wr_n !== exp_wr(m_busy, m_phase) || src_addr !== m_src || dst_addr !== m_dst) begin
      n_bad++;
      $display("FAIL %s cycle: actual busy=%b done=%b rd=%b wr=%b src=%h dst=%h expected busy=%b done=%b rd=%b wr=%b src=%h dst=%h",
               tag, busy, done, rd_n, wr_n, src_addr, dst_addr, m_busy, m_done,
               exp_rd(m_busy, m_phase), exp_wr(m_busy, m_phase), m_src, m_dst);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [PW-1:0] p, input logic [AW-1:0] a, input logic [AW-1:0] b);
    wr(2'd0, AW'(p)); wr(2'd1, a); wr(2'd2, b);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int b, r, w, guard;
    void'($urandom(32'd1234));
    repeat (3) step();
    rst = 1'b0;
    step();
    tag = "R1";
    chk(busy == 0 && done == 0 && rd_n && wr_n && dst_addr == 0 && src_addr == 0,
        "R1", "reset state", {busy, done, rd_n, wr_n}, 4'b0011);

    // basic run of three transfers
    tag = "R4";
    setup(8'h40, 16'h0100, 16'h0103);
    wr(2'd3, 16'h0001);
    chk(busy && src_addr == 8'h40 && dst_addr == 16'h0100 && !done, "R4", "start load",
        dst_addr, 16'h0100);
    tag = "R2";
    b = 0; r = 0; w = 0; guard = 0;
    while (busy && guard < 100) begin
      if (!rd_n) r++;
      if (!wr_n) w++;
      b++; guard++;
      step();
    end
    chk(b == 12, "R6", "busy cycles", b, 12);
    chk(r == 6, "R2", "read low cycles", r, 6);
    chk(w == 3, "R2", "write low cycles", w, 3);
    chk(dst_addr == 16'h0103 && src_addr == 8'h43, "R5", "final addresses", dst_addr, 16'h0103);
    chk(done == 1, "R6", "done at stop", done, 1);
    tag = "R11";
    repeat (5) step();
    chk(done == 1 && rd_n && wr_n, "R11", "done sticky", done, 1);
    chk(rd_n && wr_n, "R3", "idle strobes", {rd_n, wr_n}, 2'b11);

    // empty block
    tag = "R7";
    setup(8'h05, 16'h0020, 16'h0020);
    wr(2'd3, 16'h0001);
    chk(!busy && done && rd_n && wr_n, "R7", "empty go", {busy, done}, 2'b01);

    // wait only at boundary
    tag = "R8";
    setup(8'h00, 16'h0030, 16'h0032);
    wr(2'd3, 16'h0001);
    wait_i = 1'b1;
    b = 0;
    for (int k = 0; k < 3; k++) begin
      chk(rd_n && wr_n, "R8", "stalled strobes", {rd_n, wr_n}, 2'b11);
      b++; step();
    end
    guard = 0;
    while (busy && guard < 100) begin
      wait_i = (m_phase != 2'd0);
      b++; guard++;
      step();
    end
    wait_i = 1'b0;
    chk(b == 11, "R8", "busy cycles with wait", b, 11);

    // writes while busy ignored
    tag = "R9";
    setup(8'h11, 16'h0200, 16'h0202);
    wr(2'd3, 16'h0001);
    wr(2'd2, 16'h02FF); wr(2'd0, 16'h0099); wr(2'd1, 16'h0300); wr(2'd3, 16'h0001);
    guard = 0;
    while (busy && guard < 100) begin guard++; step(); end
    chk(dst_addr == 16'h0202 && done, "R9", "stop write ignored", dst_addr, 16'h0202);
    wr(2'd3, 16'h0001);
    chk(src_addr == 8'h11 && dst_addr == 16'h0200, "R9", "ptr/start ignored", src_addr, 8'h11);

    // abort mid transfer
    tag = "R10";
    step();
    wr(2'd3, 16'h0002);
    chk(!busy && !done && rd_n && wr_n && dst_addr == 16'h0200, "R10", "abort mid",
        dst_addr, 16'h0200);

    // abort on the completing cycle
    setup(8'h70, 16'h0400, 16'h0401);
    wr(2'd3, 16'h0001);
    guard = 0;
    while (m_phase != 2'd3 && guard < 10) begin guard++; step(); end
    wr(2'd3, 16'h0002);
    chk(!busy && !done && dst_addr == 16'h0400 && src_addr == 8'h70, "R10",
        "abort beats completion", {busy, done}, 2'b00);

    // random runs
    for (int run = 0; run < 40; run++) begin
      logic [AW-1:0] s0;
      tag = "R5";
      s0 = AW'($urandom);
      setup(PW'($urandom), s0, s0 + AW'(1 + $urandom % 5));
      wr(2'd3, 16'h0001);
      guard = 0;
      while (m_busy && guard < 500) begin
        wait_i = ($urandom % 4 == 0);
        if ($urandom % 60 == 0) wr(2'd3, 16'h0002);
        else if ($urandom % 8 == 0) wr(2'($urandom % 4), AW'($urandom) & ~AW'(2));
        else step();
        guard++;
      end
      wait_i = 1'b0;
      chk(!busy, "R6", "random run ends", busy, 0);
    end

    finished = 1'b1;
    finish_run();
  end
endmodule